// File: doc/BRIEF.md
# Prioritized Seven-Segment Display Controller

This block drives a multiplexed common-cathode seven-segment display with four full decimal digits and a leading half digit. The half digit can show only a leading "1" and a minus sign. A host sets plain control bits and data registers through a small address/data/write-strobe port. Those bits decide which of five sources reaches the display. From highest to lowest priority the sources are:

- raw per-segment patterns written by the host
- a host-written display value
- the frozen current value (hold)
- a tracked peak of the converter results
- the latest converter result

A free-running timer makes a slow refresh tick. Only on that tick is the chosen value clamped to ±MAG_LIMIT and latched. The latched value is then split into sign and magnitude and converted to BCD by a sequential shift-and-add-3 engine. Each digit is encoded into segments, and the digits are scanned one at a time with a dark cycle between them. The controller also holds a clock-source select bit. It leaves the bit low after reset and drives it out to an external clock multiplexer.

Top module: `seg_display_ctl`

## Requirements
- R1: With control bit 0 (segment override) set, each digit k shows the byte written at register address 2+k within two cycles, whatever the other control bits are and without waiting for a tick. Byte bits 0..6 drive segments a..g and bit 7 drives the decimal point.
- R2: With bit 0 clear and bit 1 (host source) set, the value written at address 1 is shown from the next refresh tick on.
- R3: With bits 0 and 1 clear and bit 2 (hold) set, the shown value stays unchanged across refresh ticks while new converter results arrive.
- R4: The peak register takes each converter result whose clamped magnitude is strictly greater than its own. The peak_clr input zeroes it on the next cycle. With bits 0 to 2 clear and bit 3 set, the peak register is the source.
- R5: With control bits 0 to 3 all clear, the source is the most recent converter result.
- R6: A refresh tick occurs every TICK_DIV cycles. The default of 1,966,080 gives 2.5 Hz at a 4.9152 MHz clock, and the refresh rate scales with the clock. The shown value changes only after a tick.
- R7: Latched values and the peak register are clamped to the range -MAG_LIMIT..+MAG_LIMIT (19999 by default).
- R8: Digits 0 to 3 show the decimal digits of the magnitude, units first, with the patterns 0=3F 1=06 2=5B 3=4F 4=66 5=6D 6=7D 7=07 8=7F 9=6F. Digit 4 lights segments b and c (06) when the magnitude is at least 10000, and segment g (40) when the value is negative.
- R9: The digit enables are active low and at most one is low at a time. Digits are scanned in the order 0,1,2,3,4. Each digit slot lasts DIGIT_HOLD cycles, and its first cycle has every enable high and every segment dark.
- R10: Control register address 0 uses bit 0 for segment override, bit 1 for host source, bit 2 for hold, bit 3 for peak and bit 4 for external clock select. All bits reset to zero, and bit 4 drives ext_clk_sel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| reg_addr | input | 3 | Host register address (0 control, 1 value, 2..6 segment bytes) |
| reg_wdata | input | VAL_W | Host write data |
| reg_we | input | 1 | Host write strobe |
| adc_data | input | VAL_W | Signed converter result |
| adc_valid | input | 1 | Converter result strobe |
| peak_clr | input | 1 | Clears the peak register |
| ext_clk_sel | output | 1 | Clock-source select, 1 = external clock |
| dig_en_n | output | 5 | Active-low digit enables, bit 4 is the half digit |
| seg | output | 8 | Segment drive, bits a..g then decimal point |

## Verification
Every cycle, the assertions check the digit-scan rules: one enable at most, a dark cycle at every change of digit, and dark segments whenever no digit is enabled. They also check the exact spacing of refresh ticks, the one-cycle clearing of the peak register and the clamp bound on the stored peak. The bench scenarios are needed for everything that depends on value flow. That covers the five-level source priority, the freezing under hold, which results win as peak, the rule that a new value appears only after a tick, and the digit and sign patterns for clamped, negative and five-digit values.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
   localparam int FULL_DIGITS = 4;
   localparam int NUM_DIGITS  = FULL_DIGITS + 1;
   localparam int BCD_W       = 4 * NUM_DIGITS;

   typedef logic [7:0] seg_t;

   // control register, bit 0 is the lowest field
   typedef struct packed {
      logic ext_clk;
      logic peak_sel;
      logic hold;
      logic host_sel;
      logic seg_sel;
   } ctrl_t;

   localparam seg_t SEG_ONE   = 8'h06;
   localparam seg_t SEG_MINUS = 8'h40;

   function automatic seg_t dec_to_seg(input logic [3:0] d);
      case (d)
         4'd0: return 8'h3F;
         4'd1: return 8'h06;
         4'd2: return 8'h5B;
         4'd3: return 8'h4F;
         4'd4: return 8'h66;
         4'd5: return 8'h6D;
         4'd6: return 8'h7D;
         4'd7: return 8'h07;
         4'd8: return 8'h7F;
         4'd9: return 8'h6F;
         default: return 8'h00;
      endcase
   endfunction
endpackage

// File: rtl/sdc_tick_gen.sv
module sdc_tick_gen #(
   parameter int TICK_DIV = 1966080
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int CNT_W = $clog2(TICK_DIV);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_DIV - 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (tick)    cnt <= '0;
      else              cnt <= cnt + 1'b1;
   end

   assign tick = (cnt == LAST);
endmodule

// File: rtl/sdc_src_select.sv
module sdc_src_select #(
   parameter int VAL_W     = 16,
   parameter int MAG_LIMIT = 19999
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    tick,
   input  logic                    host_sel,
   input  logic                    hold,
   input  logic                    peak_sel,
   input  logic signed [VAL_W-1:0] user_val,
   input  logic signed [VAL_W-1:0] adc_data,
   input  logic                    adc_valid,
   input  logic                    peak_clr,
   output logic signed [VAL_W-1:0] shown_val,
   output logic signed [VAL_W-1:0] peak_val,
   output logic                    load
);
   localparam logic signed [VAL_W-1:0] LIM_P = VAL_W'(MAG_LIMIT);
   localparam logic signed [VAL_W-1:0] LIM_N = -LIM_P;

   function automatic logic signed [VAL_W-1:0] clamp(input logic signed [VAL_W-1:0] v);
      if (v > LIM_P) return LIM_P;
      if (v < LIM_N) return LIM_N;
      return v;
   endfunction

   function automatic logic [VAL_W-1:0] mag(input logic signed [VAL_W-1:0] v);
      logic [VAL_W-1:0] r;
      r = (v < 0) ? VAL_W'(-v) : VAL_W'(v);
      return r;
   endfunction

   logic signed [VAL_W-1:0] live_q;
   logic signed [VAL_W-1:0] adc_c;
   logic                    peak_win;

   always_comb begin
      adc_c    = clamp(adc_data);
      peak_win = adc_valid && (mag(adc_c) > mag(peak_val));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live_q    <= '0;
         peak_val  <= '0;
         shown_val <= '0;
         load      <= 1'b0;
      end else begin
         load <= tick;
         if (adc_valid) live_q <= adc_data;
         if (peak_clr)      peak_val <= '0;
         else if (peak_win) peak_val <= adc_c;
         if (tick) begin
            if (host_sel)      shown_val <= clamp(user_val);
            else if (hold)     shown_val <= shown_val;
            else if (peak_sel) shown_val <= peak_val;
            else               shown_val <= clamp(live_q);
         end
      end
   end
endmodule

// File: rtl/sdc_bin2bcd.sv
module sdc_bin2bcd
   import sdc_pkg::*;
#(
   parameter int VAL_W = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic signed [VAL_W-1:0] value,
   output logic [BCD_W-1:0]        bcd,
   output logic                    neg
);
   localparam int MAG_W = VAL_W - 1;
   localparam int SH_W  = BCD_W + MAG_W;
   localparam int CNT_W = $clog2(MAG_W + 1);

   logic [SH_W-1:0]  sh, adj, nxt;
   logic [MAG_W-1:0] mag_in;
   logic [CNT_W-1:0] left;
   logic             busy, neg_w;

   always_comb begin
      mag_in = (value < 0) ? MAG_W'(-value) : MAG_W'(value);
      adj = sh;
      for (int k = 0; k < NUM_DIGITS; k++) begin
         if (sh[MAG_W + 4*k +: 4] >= 4'd5)
            adj[MAG_W + 4*k +: 4] = sh[MAG_W + 4*k +: 4] + 4'd3;
      end
      nxt = {adj[SH_W-2:0], 1'b0};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh    <= '0;
         left  <= '0;
         busy  <= 1'b0;
         neg_w <= 1'b0;
         bcd   <= '0;
         neg   <= 1'b0;
      end else if (start) begin
         sh    <= {{BCD_W{1'b0}}, mag_in};
         left  <= CNT_W'(MAG_W);
         busy  <= 1'b1;
         neg_w <= (value < 0);
      end else if (busy) begin
         sh   <= nxt;
         left <= left - 1'b1;
         if (left == CNT_W'(1)) begin
            busy <= 1'b0;
            bcd  <= nxt[SH_W-1:MAG_W];
            neg  <= neg_w;
         end
      end
   end
endmodule

// File: rtl/sdc_scan.sv
module sdc_scan
   import sdc_pkg::*;
#(
   parameter int DIGIT_HOLD = 256
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [NUM_DIGITS-1:0][7:0]       pat,
   output logic [NUM_DIGITS-1:0]            dig_en_n,
   output seg_t                             seg
);
   localparam int SLOT_W = $clog2(DIGIT_HOLD);
   localparam int IDX_W  = $clog2(NUM_DIGITS);
   localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(DIGIT_HOLD - 1);
   localparam logic [IDX_W-1:0]  IDX_LAST  = IDX_W'(NUM_DIGITS - 1);

   logic [SLOT_W-1:0] slot;
   logic [IDX_W-1:0]  idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot <= '0;
         idx  <= '0;
      end else if (slot == SLOT_LAST) begin
         slot <= '0;
         idx  <= (idx == IDX_LAST) ? '0 : idx + 1'b1;
      end else begin
         slot <= slot + 1'b1;
      end
   end

   always_comb begin
      dig_en_n = '1;
      seg      = '0;
      if (slot != '0) begin
         dig_en_n[idx] = 1'b0;
         seg           = pat[idx];
      end
   end
endmodule

// File: rtl/seg_display_ctl.sv
module seg_display_ctl
   import sdc_pkg::*;
#(
   parameter int TICK_DIV   = 1966080,
   parameter int DIGIT_HOLD = 256,
   parameter int VAL_W      = 16,
   parameter int MAG_LIMIT  = 19999
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [2:0]              reg_addr,
   input  logic [VAL_W-1:0]        reg_wdata,
   input  logic                    reg_we,
   input  logic signed [VAL_W-1:0] adc_data,
   input  logic                    adc_valid,
   input  logic                    peak_clr,
   output logic                    ext_clk_sel,
   output logic [NUM_DIGITS-1:0]   dig_en_n,
   output logic [7:0]              seg
);
   localparam logic [2:0] ADDR_CTRL = 3'd0;
   localparam logic [2:0] ADDR_USER = 3'd1;
   localparam int         SEG_BASE  = 2;

   generate
      if (TICK_DIV < 64)
         $error("TICK_DIV must leave room for the BCD conversion");
      if (DIGIT_HOLD < 2)
         $error("DIGIT_HOLD must allow a dark cycle and a lit cycle");
      if (VAL_W < 16 || VAL_W > 31)
         $error("VAL_W out of supported range");
      if (MAG_LIMIT < 1 || MAG_LIMIT > 19999)
         $error("MAG_LIMIT must fit four and a half digits");
   endgenerate

   ctrl_t                   ctrl_q;
   logic signed [VAL_W-1:0] user_q;
   logic                    refresh_tick;
   logic                    load;
   logic signed [VAL_W-1:0] shown_val;
   logic signed [VAL_W-1:0] peak_val;
   logic [BCD_W-1:0]        bcd;
   logic                    neg;
   logic [NUM_DIGITS-1:0][7:0] raw_pat;
   logic [NUM_DIGITS-1:0][7:0] enc_pat;
   logic [NUM_DIGITS-1:0][7:0] sel_pat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         user_q <= '0;
      end else if (reg_we) begin
         if (reg_addr == ADDR_CTRL) ctrl_q <= ctrl_t'(reg_wdata[$bits(ctrl_t)-1:0]);
         if (reg_addr == ADDR_USER) user_q <= reg_wdata;
      end
   end

   assign ext_clk_sel = ctrl_q.ext_clk;

   // raw segment byte per digit, and the decoded pattern per full digit
   generate
      for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_raw
         seg_t raw_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               raw_r <= '0;
            else if (reg_we && reg_addr == 3'(SEG_BASE + k))
               raw_r <= reg_wdata[7:0];
         end
         assign raw_pat[k] = raw_r;
      end
      for (genvar k = 0; k < FULL_DIGITS; k++) begin : g_enc
         assign enc_pat[k] = dec_to_seg(bcd[4*k +: 4]);
      end
   endgenerate

   assign enc_pat[FULL_DIGITS] = ((bcd[BCD_W-4 +: 4] != 4'd0) ? SEG_ONE : 8'h00)
                               | (neg ? SEG_MINUS : 8'h00);
   assign sel_pat = ctrl_q.seg_sel ? raw_pat : enc_pat;

   sdc_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (refresh_tick)
   );

   sdc_src_select #(.VAL_W(VAL_W), .MAG_LIMIT(MAG_LIMIT)) u_src (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (refresh_tick),
      .host_sel (ctrl_q.host_sel),
      .hold     (ctrl_q.hold),
      .peak_sel (ctrl_q.peak_sel),
      .user_val (user_q),
      .adc_data (adc_data),
      .adc_valid(adc_valid),
      .peak_clr (peak_clr),
      .shown_val(shown_val),
      .peak_val (peak_val),
      .load     (load)
   );

   sdc_bin2bcd #(.VAL_W(VAL_W)) u_bcd (
      .clk  (clk),
      .rst_n(rst_n),
      .start(load),
      .value(shown_val),
      .bcd  (bcd),
      .neg  (neg)
   );

   sdc_scan #(.DIGIT_HOLD(DIGIT_HOLD)) u_scan (
      .clk     (clk),
      .rst_n   (rst_n),
      .pat     (sel_pat),
      .dig_en_n(dig_en_n),
      .seg     (seg)
   );
endmodule

// File: rtl/sdc_checker.sv
module sdc_checker
   import sdc_pkg::*;
#(
   parameter int TICK_DIV  = 1966080,
   parameter int VAL_W     = 16,
   parameter int MAG_LIMIT = 19999
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    tick,
   input logic                    peak_clr,
   input logic signed [VAL_W-1:0] peak_val,
   input logic [NUM_DIGITS-1:0]   dig_en_n,
   input logic [7:0]              seg
);
   localparam logic signed [VAL_W-1:0] LIM_P = VAL_W'(MAG_LIMIT);
   localparam logic signed [VAL_W-1:0] LIM_N = -LIM_P;

   logic [31:0] since_tick;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    since_tick <= '0;
      else if (tick) since_tick <= '0;
      else           since_tick <= since_tick + 1'b1;
   end

   assert_tick_period_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> (since_tick == 32'(TICK_DIV - 1)));

   assert_digit_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~dig_en_n));

   assert_dark_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (dig_en_n != '1 && $past(dig_en_n) != '1) |-> (dig_en_n == $past(dig_en_n)));

   assert_dark_segments_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (dig_en_n == '1) |-> (seg == 8'h00));

   assert_peak_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      peak_clr |=> (peak_val == '0));

   assert_peak_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (peak_val <= LIM_P) && (peak_val >= LIM_N));
endmodule

bind seg_display_ctl sdc_checker #(
   .TICK_DIV (TICK_DIV),
   .VAL_W    (VAL_W),
   .MAG_LIMIT(MAG_LIMIT)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .tick    (refresh_tick),
   .peak_clr(peak_clr),
   .peak_val(peak_val),
   .dig_en_n(dig_en_n),
   .seg     (seg)
);

// File: tb/seg_display_ctl_tb_top.sv
`timescale 1ns/1ps
module seg_display_ctl_tb_top;
   localparam int TD = 256;
   localparam int DH = 8;
   localparam int SETTLE = 24;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [2:0]         reg_addr = '0;
   logic [15:0]        reg_wdata = '0;
   logic               reg_we = 1'b0;
   logic signed [15:0] adc_data = '0;
   logic               adc_valid = 1'b0;
   logic               peak_clr = 1'b0;
   logic               ext_clk_sel;
   logic [4:0]         dig_en_n;
   logic [7:0]         seg;

   int cyc = 0;
   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;
   always @(posedge clk) if (rst_n) cyc <= cyc + 1;

   seg_display_ctl #(.TICK_DIV(TD), .DIGIT_HOLD(DH)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_we(reg_we), .adc_data(adc_data), .adc_valid(adc_valid),
      .peak_clr(peak_clr), .ext_clk_sel(ext_clk_sel), .dig_en_n(dig_en_n), .seg(seg)
   );

   localparam logic [7:0] DTAB [10] = '{8'h3F, 8'h06, 8'h5B, 8'h4F, 8'h66,
                                        8'h6D, 8'h7D, 8'h07, 8'h7F, 8'h6F};

   // stimulus table: control bits, host value, converter result, expected shown value
   localparam int NV = 7;
   localparam logic [4:0] V_CTRL [NV] = '{5'h00, 5'h00, 5'h00, 5'h00, 5'h02, 5'h02, 5'h00};
   localparam int V_USER [NV] = '{0, 0, 0, 0, 10005, -8, 0};
   localparam int V_ADC  [NV] = '{1234, -567, 25000, -32768, 7, 7, 0};
   localparam int V_EXP  [NV] = '{1234, -567, 19999, -19999, 10005, -8, 0};

   function automatic logic [39:0] exp_disp(input int v);
      logic [39:0] d;
      int m;
      m = (v < 0) ? -v : v;
      for (int k = 0; k < 4; k++) begin
         d[8*k +: 8] = DTAB[m % 10];
         m = m / 10;
      end
      d[39:32] = ((m != 0) ? 8'h06 : 8'h00) | ((v < 0) ? 8'h40 : 8'h00);
      return d;
   endfunction

   task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   task automatic write_reg(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic feed(input int v);
      @(negedge clk);
      adc_data = 16'(v); adc_valid = 1'b1;
      @(negedge clk);
      adc_valid = 1'b0;
   endtask

   task automatic pulse_clr();
      @(negedge clk);
      peak_clr = 1'b1;
      @(negedge clk);
      peak_clr = 1'b0;
   endtask

   task automatic wait_update();
      do @(negedge clk); while ((cyc % TD) != SETTLE);
   endtask

   task automatic read_disp(output logic [39:0] d);
      d = '0;
      repeat (2 * 5 * DH) begin
         @(negedge clk);
         for (int k = 0; k < 5; k++)
            if (!dig_en_n[k]) d[8*k +: 8] = seg;
      end
   endtask

   initial begin
      repeat (2000000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      logic [39:0] got;
      int lit;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // reset state
      check("R10 ext_clk_sel after reset", {39'd0, ext_clk_sel}, 40'd0);
      read_disp(got);
      check("R8 reset display shows zero", got, exp_disp(0));

      // table walk
      for (int i = 0; i < NV; i++) begin
         write_reg(3'd0, {11'd0, V_CTRL[i]});
         write_reg(3'd1, 16'(V_USER[i]));
         feed(V_ADC[i]);
         wait_update();
         read_disp(got);
         check($sformatf("vector %0d R2 R5 R7 R8", i), got, exp_disp(V_EXP[i]));
      end

      // R6: a host write becomes visible only after the tick
      write_reg(3'd1, 16'd4444);
      write_reg(3'd0, 16'h0002);
      read_disp(got);
      check("R6 no change before tick", got, exp_disp(0));
      wait_update();
      read_disp(got);
      check("R6 change after tick", got, exp_disp(4444));

      // R10: clock select bit
      write_reg(3'd0, 16'h0010);
      check("R10 ext_clk_sel set", {39'd0, ext_clk_sel}, 40'd1);
      write_reg(3'd0, 16'h0000);
      check("R10 ext_clk_sel cleared", {39'd0, ext_clk_sel}, 40'd0);

      // R3: hold freezes the value
      feed(1234);
      wait_update();
      write_reg(3'd0, 16'h0004);
      feed(4321);
      wait_update();
      read_disp(got);
      check("R3 hold keeps value", got, exp_disp(1234));
      feed(-99);
      wait_update();
      read_disp(got);
      check("R3 hold across second tick", got, exp_disp(1234));

      // R4: peak tracking and clear
      pulse_clr();
      feed(300); feed(-900); feed(500); feed(900); feed(899);
      write_reg(3'd0, 16'h0008);
      wait_update();
      read_disp(got);
      check("R4 peak keeps first largest magnitude", got, exp_disp(-900));
      pulse_clr();
      wait_update();
      read_disp(got);
      check("R4 peak cleared to zero", got, exp_disp(0));
      feed(30000);
      wait_update();
      read_disp(got);
      check("R4 R7 peak clamped", got, exp_disp(19999));

      // R1: segment override beats every other control
      for (int k = 0; k < 5; k++) write_reg(3'(2 + k), 16'(8'hA1 + 8'h11 * k));
      write_reg(3'd0, 16'h000F);
      @(negedge clk);
      read_disp(got);
      check("R1 raw segments shown", got, 40'hE5_D4_C3_B2_A1);

      // R9: slot timing in the scan
      do @(negedge clk); while (dig_en_n != 5'b11101);
      do @(negedge clk); while (dig_en_n != 5'b11110);
      lit = 0;
      while (dig_en_n == 5'b11110) begin
         lit++;
         @(negedge clk);
      end
      check("R9 lit cycles per digit", 40'(lit), 40'(DH - 1));
      check("R9 dark cycle between digits", {32'd0, 3'd0, dig_en_n}, {32'd0, 3'd0, 5'b11111});
      check("R9 dark cycle segments", {32'd0, seg}, 40'd0);
      @(negedge clk);
      check("R9 next digit in order", {32'd0, 3'd0, dig_en_n}, {32'd0, 3'd0, 5'b11101});

      summary();
      $finish;
   end
endmodule